// File: doc/BRIEF.md
# Serial Command Interface Controller

This block is a synchronous slave for a four-wire serial link made of a serial clock, an active-low select, data in and data out. It sits in front of a bank of small data registers that feed converter inputs. The serial pins are resynchronised to a fast system clock, and the edges of the serial clock are detected there, so the whole block runs in one clock domain.

After select falls, the block waits for the first logic 1 on data in. That bit opens a frame. It is followed by a two-bit opcode and a register address, and then eight data clocks whose meaning depends on the opcode:
- A read shifts the addressed register out.
- A write loads the addressed register.
- A recall copies the matching nonvolatile value, supplied by a separate nonvolatile controller, into the register and tells that controller about it.
- An enable command passes a write-enable request on to the nonvolatile controller.

A frame cut short by select rising is abandoned. While the nonvolatile controller reports busy, all traffic is ignored.

Top module: `sercmd_ctrl`

## Requirements
- R1: After reset every data register reads zero, `sdo_en_o` is low and neither request output pulses.
- R2: While select is high, serial clocks have no effect. After select falls, zeros clocked in before the first 1 are skipped, and that 1 starts the frame.
- R3: Opcode `01` (opcode bits are sent first, then the address MSB first, then data MSB first) writes the eight data bits into the addressed register, in the system-clock cycles following the eighth data rising edge. The register is unchanged after seven bits.
- R4: Opcode `10` drives the addressed register out MSB first, one bit per serial falling edge, over the eight data clocks. `sdo_en_o` is high only during those clocks, and the register contents stay unchanged.
- R5: Opcode `11` copies nonvolatile slice `nv_image_i[a*8 +: 8]` into register `a`. It gives one single-cycle `rcl_req_o` pulse with `req_addr_o` equal to `a`, needs no data bits, and ignores any data bits that follow.
- R6: Opcode `00` gives one single-cycle `nv_wen_req_o` pulse and changes no register, whatever data bits follow.
- R7: Select rising mid-frame clears the frame state at once. A partial write leaves the register unchanged, and the next frame decodes normally.
- R8: While `nv_busy_i` is high, frames are ignored: no register changes, no request pulses, and `sdo_en_o` stays low.
- R9: After a write completes, further clocks within the same select are ignored. A new frame needs select to rise and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sel_n_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| nv_busy_i | input | 1 | Nonvolatile controller busy |
| nv_image_i | input | 32 | Nonvolatile values, register a at bits a*8+7..a*8 |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Data-out drive enable; low means high-impedance |
| dac_o | output | 32 | Data registers, register a at bits a*8+7..a*8 |
| rcl_req_o | output | 1 | Recall notification pulse |
| nv_wen_req_o | output | 1 | Nonvolatile write-enable request pulse |
| req_addr_o | output | 2 | Register address of the current frame |

## Verification
The assertions assume that the serial clock, select and data in change slowly compared with the system clock. Each serial clock level must last well beyond the synchroniser and edge-detect delay, so that no serial edge is missed or merged. They also assume that `nv_busy_i` is already synchronous to `clk`.

The stimulus holds each serial level for eight system clocks. It changes data in only while the serial clock is low, and it changes select only with the serial clock low. It then sweeps every address with many data patterns for writes, reads and recalls, as well as the abort, busy and out-of-frame cases.

// File: rtl/sercmd_pkg.sv
// Shared types for the serial command controller.
// Assumes a 2-bit opcode whose encoding is fixed by the serial protocol.
package sercmd_pkg;
    typedef enum logic [1:0] {
        CMD_NVEN   = 2'b00,
        CMD_WRITE  = 2'b01,
        CMD_READ   = 2'b10,
        CMD_RECALL = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HDR,
        ST_DATA,
        ST_DONE
    } state_e;
endpackage

// File: rtl/sercmd_sync.sv
// Multi-bit, multi-stage synchroniser for slow asynchronous pins.
// Assumes each bit is independent: no coherence between bits is needed.
module sercmd_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // pass along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sercmd_frame.sv
// Frame decoder: hunts for the start bit, collects opcode and address,
// then runs the data phase for the decoded command.
// Assumes synchronised pins and serial levels lasting several clk cycles.
module sercmd_frame
    import sercmd_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG),
    localparam int HW  = 2 + AW,
    localparam int CW  = $clog2(DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sel_n_s,
    input  logic               sdi_s,
    input  logic               busy_i,
    input  logic [NREG*DW-1:0] regs_i,
    output logic [AW-1:0]      addr_o,
    output logic               wr_stb_o,
    output logic [DW-1:0]      wr_data_o,
    output logic               rcl_stb_o,
    output logic               en_stb_o,
    output logic               sdo_o,
    output logic               sdo_en_o
);
    state_e         state;
    cmd_e           cmd;
    logic           sclk_d;
    logic [CW-1:0]  cnt;
    logic [HW-2:0]  hdr;
    logic [DW-2:0]  sh_in;
    logic [DW-1:0]  sh_out;
    logic [DW-1:0]  reg_arr [NREG];

    logic           rise, fall, abort;
    logic [HW-1:0]  hdr_next;
    cmd_e           cmd_n;
    logic [AW-1:0]  addr_n;

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_view
            assign reg_arr[i] = regs_i[i*DW +: DW];
        end
    endgenerate

    // edge detection and header decode helpers
    always_comb begin
        rise     = sclk_s & ~sclk_d;
        fall     = ~sclk_s & sclk_d;
        abort    = sel_n_s | busy_i;
        hdr_next = {hdr, sdi_s};
        cmd_n    = cmd_e'(hdr_next[HW-1 -: 2]);
        addr_n   = hdr_next[AW-1:0];
    end

    // delayed serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // frame sequencing, shifting and single-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            cmd       <= CMD_NVEN;
            cnt       <= '0;
            hdr       <= '0;
            sh_in     <= '0;
            sh_out    <= '0;
            addr_o    <= '0;
            wr_stb_o  <= 1'b0;
            wr_data_o <= '0;
            rcl_stb_o <= 1'b0;
            en_stb_o  <= 1'b0;
            sdo_o     <= 1'b0;
            sdo_en_o  <= 1'b0;
        end else begin
            wr_stb_o  <= 1'b0;
            rcl_stb_o <= 1'b0;
            en_stb_o  <= 1'b0;
            if (abort) begin
                state    <= ST_HUNT;
                cnt      <= '0;
                sdo_en_o <= 1'b0;
            end else if (rise) begin
                case (state)
                    ST_HUNT: begin
                        if (sdi_s) begin
                            state <= ST_HDR;
                            cnt   <= '0;
                        end
                    end
                    ST_HDR: begin
                        hdr <= hdr_next[HW-2:0];
                        if (cnt == CW'(HW-1)) begin
                            cnt    <= '0;
                            cmd    <= cmd_n;
                            addr_o <= addr_n;
                            case (cmd_n)
                                CMD_READ: begin
                                    sh_out <= reg_arr[addr_n];
                                    state  <= ST_DATA;
                                end
                                CMD_WRITE: state <= ST_DATA;
                                CMD_RECALL: begin
                                    rcl_stb_o <= 1'b1;
                                    state     <= ST_DONE;
                                end
                                default: begin
                                    en_stb_o <= 1'b1;
                                    state    <= ST_DONE;
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        sh_in <= {sh_in[DW-3:0], sdi_s};
                        if (cnt == CW'(DW-1)) begin
                            state    <= ST_DONE;
                            sdo_en_o <= 1'b0;
                            if (cmd == CMD_WRITE) begin
                                wr_stb_o  <= 1'b1;
                                wr_data_o <= {sh_in, sdi_s};
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (fall && state == ST_DATA && cmd == CMD_READ) begin
                sdo_o    <= sh_out[DW-1];
                sh_out   <= {sh_out[DW-2:0], 1'b0};
                sdo_en_o <= 1'b1;
            end
        end
    end

    // R8: busy silences the interface on the next cycle
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (!sdo_en_o && !wr_stb_o && !rcl_stb_o && !en_stb_o));

    // R2: deselect silences the interface on the next cycle
    p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (!sdo_en_o && !wr_stb_o && !rcl_stb_o && !en_stb_o));

    // R3: a write strobe lasts one cycle
    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R5: a recall strobe lasts one cycle
    p_rcl_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rcl_stb_o |=> !rcl_stb_o);

    // R6: an enable request lasts one cycle
    p_en_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_stb_o |=> !en_stb_o);

    // R4: the output enable only rises on a serial falling edge
    p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en_o) |-> $past(fall));
endmodule

// File: rtl/sercmd_regbank.sv
// Bank of data registers loaded by write or recall strobes.
// Assumes at most one strobe per cycle, with the address held stable.
module sercmd_regbank #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr_i,
    input  logic               wr_stb_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic               rcl_stb_i,
    input  logic [NREG*DW-1:0] nv_image_i,
    output logic [NREG*DW-1:0] regs_o
);
    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            // one data register: write has priority over recall
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_o[i*DW +: DW] <= '0;
                else if (wr_stb_i && addr_i == AW'(i))
                    regs_o[i*DW +: DW] <= wr_data_i;
                else if (rcl_stb_i && addr_i == AW'(i))
                    regs_o[i*DW +: DW] <= nv_image_i[i*DW +: DW];
            end
        end
    endgenerate

    // R3: registers hold without a strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb_i && !rcl_stb_i) |=> $stable(regs_o));

    // R5: write and recall never collide
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb_i && rcl_stb_i));
endmodule

// File: rtl/sercmd_ctrl.sv
// Top of the serial command controller: pin synchroniser, frame decoder
// and data register bank. Assumes the serial clock is much slower than clk.
module sercmd_ctrl #(
    parameter int DW     = 8,
    parameter int NREG   = 4,
    parameter int STAGES = 2,
    localparam int AW    = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sel_n_i,
    input  logic               sdi_i,
    input  logic               nv_busy_i,
    input  logic [NREG*DW-1:0] nv_image_i,
    output logic               sdo_o,
    output logic               sdo_en_o,
    output logic [NREG*DW-1:0] dac_o,
    output logic               rcl_req_o,
    output logic               nv_wen_req_o,
    output logic [AW-1:0]      req_addr_o
);
    logic          sel_n_s, sclk_s, sdi_s;
    logic [AW-1:0] addr;
    logic          wr_stb, rcl_stb, en_stb;
    logic [DW-1:0] wr_data;

    sercmd_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, sclk_i, sdi_i}),
        .q_o   ({sel_n_s, sclk_s, sdi_s})
    );

    sercmd_frame #(.DW(DW), .NREG(NREG)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sel_n_s   (sel_n_s),
        .sdi_s     (sdi_s),
        .busy_i    (nv_busy_i),
        .regs_i    (dac_o),
        .addr_o    (addr),
        .wr_stb_o  (wr_stb),
        .wr_data_o (wr_data),
        .rcl_stb_o (rcl_stb),
        .en_stb_o  (en_stb),
        .sdo_o     (sdo_o),
        .sdo_en_o  (sdo_en_o)
    );

    sercmd_regbank #(.DW(DW), .NREG(NREG)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .wr_stb_i   (wr_stb),
        .wr_data_i  (wr_data),
        .rcl_stb_i  (rcl_stb),
        .nv_image_i (nv_image_i),
        .regs_o     (dac_o)
    );

    assign rcl_req_o    = rcl_stb;
    assign nv_wen_req_o = en_stb;
    assign req_addr_o   = addr;

    // R6: an enable request never coincides with a recall
    p_req_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rcl_req_o && nv_wen_req_o));
endmodule

// File: tb/sercmd_ctrl_test.sv
module sercmd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0, busy = 1'b0;
    logic [31:0] nv_image = '0;
    logic        sdo, sdo_en, rcl_req, wen_req;
    logic [31:0] dac;
    logic [1:0]  req_addr;

    int checks = 0, fails = 0, rcl_cnt = 0, wen_cnt = 0;
    logic [1:0] rcl_addr = '0;
    logic [7:0] model [4];
    bit done = 0;

    sercmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .sdi_i(sdi),
        .nv_busy_i(busy), .nv_image_i(nv_image), .sdo_o(sdo), .sdo_en_o(sdo_en),
        .dac_o(dac), .rcl_req_o(rcl_req), .nv_wen_req_o(wen_req), .req_addr_o(req_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rcl_req) begin
            rcl_cnt  <= rcl_cnt + 1;
            rcl_addr <= req_addr;
        end
        if (wen_req) wen_cnt <= wen_cnt + 1;
    end

    function automatic logic [31:0] mflat();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic q, output logic e);
        sdi = b;
        tick(HALF);
        q = sdo;
        e = sdo_en;
        sclk = 1'b1;
        tick(HALF);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [15:0] bits, input int n, inout bit en_any);
        logic q, e;
        for (int k = n - 1; k >= 0; k--) begin
            sbit(bits[k], q, e);
            if (e) en_any = 1;
        end
    endtask

    task automatic open_sel();
        sel_n = 1'b0;
        tick(HALF);
    endtask

    task automatic close_sel();
        sel_n = 1'b1;
        tick(2*HALF);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        bit ea = 0;
        open_sel();
        send({3'b101, a, d}, 13, ea);
        close_sel();
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d,
                           output bit en_all, output bit en_any);
        logic q, e;
        bit pre = 0;
        en_all = 1;
        en_any = 0;
        open_sel();
        send({3'b110, a}, 5, pre);
        for (int k = 7; k >= 0; k--) begin
            sbit(1'b0, q, e);
            d[k] = q;
            if (!e) en_all = 0;
            if (e) en_any = 1;
        end
        close_sel();
        if (pre || sdo_en) en_all = 0;
        if (pre) en_any = 1;
    endtask

    task automatic do_recall(input logic [1:0] a, input int ndata);
        bit ea = 0;
        open_sel();
        send({3'b111, a}, 5, ea);
        if (ndata > 0) send(16'hFFFF, ndata, ea);
        close_sel();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        bit en_all, en_any;
        int rc0, wc0;
        logic [31:0] snap;
        for (int a = 0; a < 4; a++) model[a] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(dac == 32'h0, "R1 registers", dac, 0);
        chk(!sdo_en, "R1 output enable", {31'b0, sdo_en}, 0);
        chk(rcl_cnt == 0 && wen_cnt == 0, "R1 requests", rcl_cnt + wen_cnt, 0);

        // R3/R4: sweep writes and read-backs over every address
        for (int p = 0; p < 6; p++) begin
            for (int a = 0; a < 4; a++) begin
                logic [7:0] v;
                v = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'((a*37 + p*91 + 5) & 255);
                do_write(2'(a), v);
                model[a] = v;
                chk(dac == mflat(), "R3 write sweep", dac, mflat());
            end
            for (int a = 0; a < 4; a++) begin
                snap = dac;
                do_read(2'(a), rd, en_all, en_any);
                chk(rd == model[a], "R4 read data", {24'b0, rd}, {24'b0, model[a]});
                chk(en_all, "R4 enable window", {31'b0, en_all}, 1);
                chk(dac == snap, "R4 read leaves register", dac, snap);
            end
        end

        // R3: commit only on the eighth data bit; R9: rest of select ignored
        begin
            logic q, e;
            bit ea = 0;
            open_sel();
            send({3'b101, 2'd2, 7'b0110100}, 12, ea);
            chk(dac == mflat(), "R3 seven bits no change", dac, mflat());
            sbit(1'b1, q, e);
            model[2] = 8'b01101001;
            chk(dac == mflat(), "R3 eighth bit commits", dac, mflat());
            send({3'b101, 2'd3, 8'h5A}, 13, ea);
            chk(dac == mflat(), "R9 no second frame", dac, mflat());
            close_sel();
            chk(dac == mflat(), "R9 after deselect", dac, mflat());
        end

        // R2: clocks with select high do nothing
        begin
            bit ea = 0;
            send({3'b101, 2'd1, 8'hC3}, 13, ea);
            tick(2*HALF);
            chk(dac == mflat() && !ea, "R2 select high ignored", dac, mflat());
        end

        // R2: leading zeros skipped before the start bit
        begin
            bit ea = 0;
            open_sel();
            send({3'b000, 3'b101, 2'd1, 8'h96}, 16, ea);
            close_sel();
            model[1] = 8'h96;
            chk(dac == mflat(), "R2 leading zeros", dac, mflat());
        end

        // R7: partial write aborted by deselect
        begin
            bit ea = 0;
            open_sel();
            send({3'b101, 2'd0, 5'b11111}, 10, ea);
            close_sel();
            chk(dac == mflat(), "R7 partial write", dac, mflat());
            open_sel();
            send({3'b110, 2'd0, 3'b000}, 8, ea);
            sel_n = 1'b1;
            tick(HALF);
            chk(!sdo_en, "R7 read cut by deselect", {31'b0, sdo_en}, 0);
            tick(HALF);
            do_write(2'd0, 8'h3E);
            model[0] = 8'h3E;
            chk(dac == mflat(), "R7 next frame decodes", dac, mflat());
        end

        // R5: recall on every address, with and without trailing bits
        nv_image = 32'h1B_E4_72_C9;
        for (int a = 0; a < 4; a++) begin
            rc0 = rcl_cnt;
            do_recall(2'(a), (a == 2) ? 8 : 0);
            model[a] = nv_image[a*8 +: 8];
            chk(dac == mflat(), "R5 recall copy", dac, mflat());
            chk(rcl_cnt == rc0 + 1, "R5 one recall pulse", rcl_cnt, rc0 + 1);
            chk(rcl_addr == 2'(a), "R5 recall address", {30'b0, rcl_addr}, a);
        end

        // R6: enable command pulses once, registers untouched
        begin
            bit ea = 0;
            wc0 = wen_cnt;
            rc0 = rcl_cnt;
            open_sel();
            send({3'b100, 2'd3, 8'hA7}, 13, ea);
            close_sel();
            chk(wen_cnt == wc0 + 1, "R6 enable pulse", wen_cnt, wc0 + 1);
            chk(dac == mflat() && rcl_cnt == rc0, "R6 no register change", dac, mflat());
        end

        // R8: busy blocks all frames
        busy = 1'b1;
        tick(2);
        rc0 = rcl_cnt;
        wc0 = wen_cnt;
        do_write(2'd1, 8'h00);
        do_read(2'd1, rd, en_all, en_any);
        chk(!en_any, "R8 no drive while busy", {31'b0, en_any}, 0);
        do_recall(2'd3, 0);
        begin
            bit ea = 0;
            open_sel();
            send({3'b100, 2'd0}, 5, ea);
            close_sel();
        end
        chk(dac == mflat(), "R8 registers unchanged", dac, mflat());
        chk(rcl_cnt == rc0 && wen_cnt == wc0, "R8 no requests", rcl_cnt + wen_cnt, rc0 + wc0);
        busy = 1'b0;
        tick(2);
        do_write(2'd1, 8'h44);
        model[1] = 8'h44;
        chk(dac == mflat(), "R8 works after busy", dac, mflat());

        done = 1;
        summary();
        $finish;
    end
endmodule